// File: doc/BRIEF.md
# Multi-Mode 16-Bit Reload Timer

This block is a 16-bit down-counter with a reload latch, reached through a byte-wide register port. Software picks a count source, writes a start value and clears a stop bit. From then on the counter steps down on each count pulse. A count pulse that arrives while the counter is at zero is an underflow. An underflow reloads the counter from the latch, counting goes on, and a sticky interrupt request flag is raised.

The block has three functions. Internal timer mode counts ticks from a power-of-two prescaler on the system clock, or ticks from an alternate clock-enable input. Event counter mode counts edges on an external pin, after the pin has been synchronised. Pulse output mode counts like the timer and also drives a pin whose level flips at each underflow. An edge-select bit in the mode register sets the starting level of that pin, and flipping this bit also flips the pin.

The 16-bit value is reached through two byte addresses in a fixed order. On a read, the high byte comes first, and that read freezes the low byte. On a write, the low byte goes first and waits in a buffer until the high-byte write commits all 16 bits.

Top module: `rld_timer16`

## Requirements
- R1: While the counter is running, each count pulse lowers the counter by one. A count pulse that finds the counter at 0x0000 reloads it from the latch, so underflows come every latch+1 count pulses.
- R2: Each underflow sets `irq_flag`. The flag stays at 1 until an `irq_ack` pulse. If an underflow and `irq_ack` fall in the same cycle, the flag ends up set.
- R3: Mode register (address 2) bit 6 = 1 stops counting: the counter keeps its value whatever count pulses arrive. Bit 6 = 0 lets it run. After reset the mode register reads 0x40.
- R4: Mode bits 2:0 = 000 with bit 7 = 0 selects timer mode. Bits 2:0 = 000 with bit 7 = 1 selects event counter mode. Bits 2:0 = 001 selects pulse output mode. Any other value of bits 2:0 stops counting.
- R5: In event counter mode the counter counts edges of `evt_pin`: rising edges when mode bit 5 = 0, falling edges when bit 5 = 1. The pin passes through a two-flop synchroniser. In this mode `alt_ce` and the prescaler have no effect, and in timer mode the pin has no effect.
- R6: A high-byte write while stopped loads both the latch and the counter. A high-byte write while running loads only the latch, and the new value is used at the next reload. If that reload happens in the same cycle as the write, it already takes the new value.
- R7: Address 1 reads the current high byte of the counter and freezes the current low byte. Address 0 then returns the frozen byte, even if the counter has moved since.
- R8: A write to address 0 changes neither the counter nor the latch. The byte is buffered and committed as bits 7:0 by the next write to address 1, which supplies bits 15:8.
- R9: In pulse output mode `pulse_out` flips on each underflow.
- R10: Any high-byte write sets the pulse level to high when mode bit 5 = 0 and low when bit 5 = 1. A mode write that changes bit 5 inverts the current pulse level.
- R11: The source select register (address 3, bits 3:0) takes codes 0 to 9 for the system clock divided by 2^(code+1), code 10 for `alt_ce`, and stops counting for codes 11 to 15.
- R12: `pulse_out` is 0 whenever the mode is not pulse output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe, one cycle |
| bus_rd | input | 1 | Register read strobe, one cycle |
| bus_addr | input | 2 | 0 counter low, 1 counter high, 2 mode, 3 source select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq_ack | input | 1 | Clears the interrupt request flag |
| alt_ce | input | 1 | Alternate count enable, one pulse per count |
| evt_pin | input | 1 | External event input, asynchronous |
| irq_flag | output | 1 | Sticky underflow request |
| pulse_out | output | 1 | Pulse output pin level |

## Verification
Two functions can land on the same clock edge: a reload of the counter from the latch, and a software commit of a new latch value by a high-byte write. The bench brings the counter to zero with `alt_ce` pulses. It then raises the high-byte write, one `alt_ce` pulse and `irq_ack` all in one cycle. It expects the counter to hold the newly written value afterwards and `irq_flag` to still be set, so it judges both the reload source and the set-over-clear priority. A second overlap, a running latch write that changes the pulse level next to underflow toggles, is checked through the `pulse_out` level.

// File: rtl/rlt_pkg.sv
package rlt_pkg;

    localparam int CNT_W     = 16;
    localparam int BYTE_W    = 8;
    localparam int DIV_CODES = 10;
    localparam int SRC_W     = 4;
    localparam int ADDR_W    = 2;

    typedef enum logic [ADDR_W-1:0] {
        ADR_LO   = 2'd0,
        ADR_HI   = 2'd1,
        ADR_MODE = 2'd2,
        ADR_SRC  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_TIMER = 2'd1,
        OP_EVENT = 2'd2,
        OP_PULSE = 2'd3
    } op_mode_e;

    // mode register layout, bit 7 down to bit 0
    typedef struct packed {
        logic       ev_sel;
        logic       stop;
        logic       edge_fall;
        logic [1:0] spare;
        logic [2:0] sel;
    } mode_reg_t;

    localparam logic [BYTE_W-1:0] MODE_RESET = 8'h40;

    function automatic op_mode_e decode_mode(input mode_reg_t m);
        if (m.sel == 3'b000)
            return m.ev_sel ? OP_EVENT : OP_TIMER;
        else if (m.sel == 3'b001)
            return OP_PULSE;
        else
            return OP_IDLE;
    endfunction

    function automatic logic start_level(input logic edge_fall);
        return ~edge_fall;
    endfunction

endpackage

// File: rtl/rlt_prescaler.sv
module rlt_prescaler #(
    parameter int DIV_CODES = rlt_pkg::DIV_CODES,
    parameter int SRC_W     = rlt_pkg::SRC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_W-1:0] src_sel,
    input  logic             alt_ce,
    output logic             tick
);
    localparam logic [SRC_W-1:0] ALT_CODE = SRC_W'(DIV_CODES);

    logic [DIV_CODES-1:0] div_cnt;
    logic [DIV_CODES-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else     div_cnt <= div_cnt + DIV_CODES'(1);
    end

    for (genvar k = 0; k < DIV_CODES; k++) begin : g_tap
        assign taps[k] = &div_cnt[k:0];
    end

    always_comb begin
        tick = 1'b0;
        if (src_sel == ALT_CODE) tick = alt_ce;
        for (int k = 0; k < DIV_CODES; k++) begin
            if (src_sel == SRC_W'(k)) tick = taps[k];
        end
    end

    AST_DIV2_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
        (src_sel == '0 && tick) |=> (src_sel != '0 || !tick)); // R11

endmodule

// File: rtl/rlt_edge_sync.sv
module rlt_edge_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic fall_sel,
    output logic edge_hit
);
    logic [SYNC_STAGES:0] shr;
    logic cur, prev;

    always_ff @(posedge clk) begin
        if (rst) shr <= '0;
        else     shr <= {shr[SYNC_STAGES-1:0], pin_in};
    end

    assign cur      = shr[SYNC_STAGES-1];
    assign prev     = shr[SYNC_STAGES];
    assign edge_hit = fall_sel ? (prev & ~cur) : (cur & ~prev);

    AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> (!edge_hit || fall_sel != $past(fall_sel))); // R5

endmodule

// File: rtl/rlt_counter_core.sv
module rlt_counter_core #(
    parameter int CNT_W = rlt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halted,
    input  logic             cnt_tick,
    input  logic             commit,
    input  logic [CNT_W-1:0] commit_val,
    output logic [CNT_W-1:0] cnt,
    output logic             uf
);
    logic [CNT_W-1:0] cnt_q, latch_q, latch_d;

    assign uf      = cnt_tick && (cnt_q == '0);
    assign latch_d = commit ? commit_val : latch_q;
    assign cnt     = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '1;
            latch_q <= '1;
        end else begin
            latch_q <= latch_d;
            if (commit && halted)
                cnt_q <= commit_val;
            else if (uf)
                cnt_q <= latch_d;
            else if (cnt_tick)
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    AST_RELOAD_FROM_LATCH: assert property (@(posedge clk) disable iff (rst)
        (uf && !commit) |=> (cnt_q == $past(latch_q))); // R1
    AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && cnt_q != '0 && !(commit && halted)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R1
    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (halted && !commit) |=> $stable(cnt_q)); // R3
    AST_RUN_WRITE_LATCH_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!halted && commit && !cnt_tick) |=> $stable(cnt_q)); // R6
    AST_HALT_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        halted |-> !cnt_tick); // R3

endmodule

// File: rtl/rld_timer16.sv
module rld_timer16
    import rlt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                irq_ack,
    input  logic                alt_ce,
    input  logic                evt_pin,
    output logic                irq_flag,
    output logic                pulse_out
);
    mode_reg_t          mode_q;
    logic [SRC_W-1:0]   src_q;
    logic [BYTE_W-1:0]  wr_buf, rd_buf;
    logic               irq_q, pulse_q;

    op_mode_e           op;
    logic               presc_tick, edge_hit, cnt_tick, uf;
    logic               commit, mode_wr, edge_flip, pulse_d;
    logic [CNT_W-1:0]   cnt;

    assign op        = decode_mode(mode_q);
    assign commit    = bus_wr && (bus_addr == ADR_HI);
    assign mode_wr   = bus_wr && (bus_addr == ADR_MODE);
    assign edge_flip = mode_wr && (bus_wdata[5] != mode_q.edge_fall);

    rlt_prescaler #(.DIV_CODES(DIV_CODES), .SRC_W(SRC_W)) u_presc (
        .clk(clk), .rst(rst), .src_sel(src_q), .alt_ce(alt_ce), .tick(presc_tick)
    );

    rlt_edge_sync #(.SYNC_STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .pin_in(evt_pin),
        .fall_sel(mode_q.edge_fall), .edge_hit(edge_hit)
    );

    always_comb begin
        unique case (op)
            OP_TIMER, OP_PULSE: cnt_tick = presc_tick;
            OP_EVENT:           cnt_tick = edge_hit;
            default:            cnt_tick = 1'b0;
        endcase
        if (mode_q.stop) cnt_tick = 1'b0;
    end

    rlt_counter_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .halted(mode_q.stop), .cnt_tick(cnt_tick),
        .commit(commit), .commit_val({bus_wdata, wr_buf}),
        .cnt(cnt), .uf(uf)
    );

    always_comb begin
        if (commit)
            pulse_d = start_level(mode_q.edge_fall);
        else
            pulse_d = pulse_q ^ (uf && op == OP_PULSE) ^ edge_flip;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= mode_reg_t'(MODE_RESET);
            src_q   <= '0;
            wr_buf  <= '0;
            rd_buf  <= '0;
            irq_q   <= 1'b0;
            pulse_q <= 1'b1;
        end else begin
            pulse_q <= pulse_d;
            if (uf)           irq_q <= 1'b1;
            else if (irq_ack) irq_q <= 1'b0;
            if (bus_wr) begin
                case (bus_addr)
                    ADR_LO:   wr_buf <= bus_wdata;
                    ADR_MODE: mode_q <= mode_reg_t'(bus_wdata);
                    ADR_SRC:  src_q  <= bus_wdata[SRC_W-1:0];
                    default:  ;
                endcase
            end
            if (bus_rd && bus_addr == ADR_HI)
                rd_buf <= cnt[BYTE_W-1:0];
        end
    end

    always_comb begin
        case (bus_addr)
            ADR_LO:   bus_rdata = rd_buf;
            ADR_HI:   bus_rdata = cnt[CNT_W-1:BYTE_W];
            ADR_MODE: bus_rdata = mode_q;
            default:  bus_rdata = {{(BYTE_W-SRC_W){1'b0}}, src_q};
        endcase
    end

    assign irq_flag  = irq_q;
    assign pulse_out = (op == OP_PULSE) && pulse_q;

    AST_IRQ_ON_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        uf |=> irq_flag); // R2
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_ack) |=> irq_flag); // R2
    AST_PULSE_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (uf && op == OP_PULSE && !commit && !edge_flip) |=> (pulse_q != $past(pulse_q))); // R9
    AST_WRITE_SETS_LEVEL: assert property (@(posedge clk) disable iff (rst)
        commit |=> (pulse_q == !$past(mode_q.edge_fall))); // R10
    AST_EDGE_BIT_INVERTS: assert property (@(posedge clk) disable iff (rst)
        (edge_flip && !uf) |=> (pulse_q != $past(pulse_q))); // R10
    AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |-> !uf); // R4

endmodule

// File: tb/rld_timer16_tb.sv
module rld_timer16_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0, alt_ce = 1'b0, evt_pin = 1'b0;
    logic       irq_flag, pulse_out;

    int total = 0, bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rld_timer16 dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .alt_ce(alt_ce), .evt_pin(evt_pin),
        .irq_flag(irq_flag), .pulse_out(pulse_out)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1; d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] h, l;
        rd(2'd1, h); rd(2'd0, l); v = {h, l};
    endtask

    task automatic set16(input logic [15:0] v);
        wr(2'd0, v[7:0]); wr(2'd1, v[15:8]);
    endtask

    task automatic ce(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); alt_ce = 1'b1;
            @(negedge clk); alt_ce = 1'b0;
        end
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic pin_pulse();
        @(negedge clk); evt_pin = 1'b1;
        repeat (4) @(negedge clk);
        evt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [15:0] v;
        rd(2'd2, b);  chk("R3", "mode after reset", b, 8'h40);
        rd(2'd3, b);  chk("R11", "source after reset", b, 0);
        rd16(v);      chk("R1", "counter after reset", v, 16'hFFFF);
        chk("R2", "irq after reset", irq_flag, 0);
        chk("R12", "pulse after reset", pulse_out, 0);
    endtask

    task automatic t_stopped_write();
        logic [15:0] v;
        wr(2'd3, 8'd10);
        wr(2'd0, 8'h34);
        rd16(v); chk("R8", "low write alone", v, 16'hFFFF);
        wr(2'd1, 8'h12);
        rd16(v); chk("R6", "stopped write loads counter", v, 16'h1234);
        ce(5);
        rd16(v); chk("R3", "stop bit holds counter", v, 16'h1234);
    endtask

    task automatic t_reload();
        logic [15:0] v;
        set16(16'd3);
        wr(2'd2, 8'h00);
        ce(3);
        rd16(v); chk("R1", "counter reaches zero", v, 0);
        chk("R2", "no irq at zero", irq_flag, 0);
        ce(1);
        rd16(v); chk("R1", "reload after latch+1 ticks", v, 3);
        chk("R2", "irq on underflow", irq_flag, 1);
        ce(1);
        chk("R2", "irq sticky", irq_flag, 1);
        ack();
        chk("R2", "irq cleared by ack", irq_flag, 0);
    endtask

    task automatic t_coincide();
        logic [15:0] v;
        ce(2);
        rd16(v); chk("R6", "counter before overlap", v, 0);
        wr(2'd0, 8'h09);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00; alt_ce = 1'b1; irq_ack = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; alt_ce = 1'b0; irq_ack = 1'b0;
        rd16(v); chk("R6", "same-cycle reload takes new latch", v, 9);
        chk("R2", "set wins over ack", irq_flag, 1);
        ack();
    endtask

    task automatic t_running_write();
        logic [15:0] v;
        set16(16'd5);
        rd16(v); chk("R6", "running write leaves counter", v, 9);
        ce(10);
        rd16(v); chk("R6", "next reload uses new latch", v, 5);
        ack();
    endtask

    task automatic t_read_coherent();
        logic [7:0] h, l;
        wr(2'd2, 8'h40);
        set16(16'h0100);
        wr(2'd2, 8'h00);
        rd(2'd1, h);
        ce(1);
        rd(2'd0, l);
        chk("R7", "high byte", h, 8'h01);
        chk("R7", "frozen low byte", l, 8'h00);
        rd(2'd1, h);
        rd(2'd0, l);
        chk("R7", "fresh read after tick", {h, l}, 16'h00FF);
    endtask

    task automatic t_event();
        logic [15:0] v;
        wr(2'd2, 8'hC0);
        set16(16'd10);
        wr(2'd2, 8'h80);
        repeat (3) pin_pulse();
        rd16(v); chk("R5", "rising edges counted", v, 7);
        ce(2);
        rd16(v); chk("R5", "alt_ce ignored in event mode", v, 7);
        wr(2'd2, 8'hA0);
        pin_pulse();
        rd16(v); chk("R5", "falling edge counted", v, 6);
        wr(2'd2, 8'h00);
        pin_pulse();
        rd16(v); chk("R5", "pin ignored in timer mode", v, 6);
    endtask

    task automatic t_idle_mode();
        logic [15:0] v;
        wr(2'd2, 8'h02);
        ce(3);
        rd16(v); chk("R4", "unused mode code does not count", v, 6);
    endtask

    task automatic t_pulse();
        wr(2'd2, 8'h41);
        set16(16'd1);
        chk("R10", "write sets high level", pulse_out, 1);
        wr(2'd2, 8'h01);
        ce(2);
        chk("R9", "flip on first underflow", pulse_out, 0);
        ce(2);
        chk("R9", "flip on second underflow", pulse_out, 1);
        wr(2'd2, 8'h21);
        chk("R10", "edge bit change inverts", pulse_out, 0);
        ce(2);
        chk("R9", "flip after edge change", pulse_out, 1);
        set16(16'd1);
        chk("R10", "running write sets low level", pulse_out, 0);
        wr(2'd2, 8'h00);
        chk("R12", "pin low outside pulse mode", pulse_out, 0);
        ack();
    endtask

    task automatic measure(input logic [3:0] code, input logic [15:0] lat, input int exp);
        int t0, t1;
        wr(2'd2, 8'h40);
        wr(2'd3, {4'd0, code});
        set16(lat);
        ack();
        wr(2'd2, 8'h00);
        while (!irq_flag) @(negedge clk);
        t0 = cyc;
        ack();
        while (!irq_flag) @(negedge clk);
        t1 = cyc;
        chk("R11", $sformatf("period for source code %0d", code), t1 - t0, exp);
        wr(2'd2, 8'h40);
        ack();
    endtask

    task automatic t_prescaler();
        logic [15:0] a, b;
        measure(4'd0, 16'd1, 4);
        measure(4'd3, 16'd0, 16);
        measure(4'd9, 16'd1, 2048);
        wr(2'd3, 8'd11);
        set16(16'd0);
        wr(2'd2, 8'h00);
        rd16(a);
        repeat (40) @(negedge clk);
        rd16(b);
        chk("R11", "unused source code stops counting", b, a);
        chk("R11", "no irq with unused source", irq_flag, 0);
        wr(2'd3, 8'd10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stopped_write();
        t_reload();
        t_coincide();
        t_running_write();
        t_read_coherent();
        t_event();
        t_idle_mode();
        t_pulse();
        t_prescaler();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule